// File: doc/BRIEF.md
# Processor Trap Detection and Arbitration

This block sits beside a processor core and watches a set of core status strobes for fault conditions that no interrupt enable can mask: arithmetic faults (divide by zero, accumulator overflow past bit 31 or bit 39, shift counts out of range), address faults (misaligned word access, unimplemented data or program space), stack faults (stack pointer above a software limit or below a fixed floor) and loss of the oscillator. Each detected fault is latched into a sticky status bit that only software can clear.

From the latched status the block picks the highest fixed level (8 to 15) and presents it to the core together with the vector address of its handler. The request is gated by the core's current priority level. Faults at levels 8 to 11 may preempt one another. Faults at 12 and above cannot be preempted. A nesting-disable bit stops any trap from preempting a trap that is already being serviced.

A two-entry register port gives software two registers. The control/status register holds the enables and the sticky status. The second register holds the stack limit.

Top module: `trap_unit`

## Requirements
- R1: After reset the control/status register (select 0) reads 0x0000, the stack limit (select 1) reads 0xFFFF, and no trap is requested.
- R2: A divide-by-zero strobe sets status bit 4 and, one cycle later, presents level 8 with vector 0x00000C.
- R3: A carry out of bit 31 of accumulator A (or B) raises level 8+1=9 only when control bit 10 (A) or bit 9 (B) is set and that accumulator's 31-bit saturation input is low.
- R4: A carry out of bit 39 of either accumulator raises level 10 only when control bit 8 is set.
- R5: A shift with a count above 16 on a word operation, or above 8 on a byte operation, raises level 11; counts at or below the bound raise nothing.
- R6: A word access at an odd address, any access at or above data address 0x2000, or a program-space access flagged unimplemented sets status bit 3 and raises level 13 with vector 0x000008.
- R7: A stack check with the pointer below 0x0800 or above the stack limit register sets status bit 2 and raises level 12 with vector 0x00000A.
- R8: An oscillator failure sets status bit 1 and raises level 14 with vector 0x000006.
- R9: When several faults are pending, the highest level is presented; all arithmetic faults share status bit 4 and vector 0x00000C, and every presented level has bit 3 set.
- R10: Status bits stay set until a write of 0 to that bit; writing 1 has no effect; a fault arriving in the same cycle as a clearing write leaves the bit set.
- R11: A request is made only when the level exceeds the core's current level, never while the core level is 12 or more, and never while the core level is 8 or more with control bit 15 (nesting disable) set.
- R12: Control bits 15, 10, 9 and 8 are writable and read back; all other non-status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_zero_i | input | 1 | Divide-by-zero attempt strobe |
| carry31_a_i | input | 1 | Accumulator A carry out of bit 31 |
| carry31_b_i | input | 1 | Accumulator B carry out of bit 31 |
| carry39_a_i | input | 1 | Accumulator A carry out of bit 39 |
| carry39_b_i | input | 1 | Accumulator B carry out of bit 39 |
| sat31_a_i | input | 1 | Accumulator A 31-bit saturation active |
| sat31_b_i | input | 1 | Accumulator B 31-bit saturation active |
| sh_valid_i | input | 1 | Shift operation strobe |
| sh_byte_i | input | 1 | Shift operates on a byte (else word) |
| sh_cnt_i | input | 5 | Shift count |
| mem_valid_i | input | 1 | Data access strobe |
| mem_word_i | input | 1 | Data access is a word access |
| mem_addr_i | input | 16 | Data effective address |
| prog_unimpl_i | input | 1 | Program-space access to unimplemented memory |
| sp_chk_i | input | 1 | Stack pointer check strobe |
| sp_i | input | 16 | Stack pointer value |
| osc_fail_i | input | 1 | Oscillator failure |
| cpu_ipl_i | input | 4 | Core's current priority level |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 1 | Register select: 0 control/status, 1 stack limit |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| trap_req_o | output | 1 | Trap request to core |
| trap_level_o | output | 4 | Highest pending trap level (0 if none) |
| trap_vec_o | output | 24 | Handler vector address of that trap |

## Verification
The two functions that share a cycle are fault capture and a software write that clears the status. The bench drives a fault strobe on the same clock edge as a control write whose status bits are zero, then reads the status and the presented level afterward. The bit must remain set. A plain clearing write on a later edge must empty it. Priority collisions are provoked by raising every subset of four fault classes in a single cycle and comparing the presented level and vector against the maximum computed in the bench.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [3:0] {
    LVL_NONE  = 4'd0,
    LVL_DIV0  = 4'd8,
    LVL_OVF   = 4'd9,
    LVL_COVF  = 4'd10,
    LVL_SHIFT = 4'd11,
    LVL_STACK = 4'd12,
    LVL_ADDR  = 4'd13,
    LVL_OSC   = 4'd14
  } trap_lvl_e;

  // control/status bit positions
  localparam int unsigned CB_NEST  = 15;
  localparam int unsigned CB_OVA   = 10;
  localparam int unsigned CB_OVB   = 9;
  localparam int unsigned CB_COV   = 8;
  localparam int unsigned ST_MATH  = 4;
  localparam int unsigned ST_ADDR  = 3;
  localparam int unsigned ST_STACK = 2;
  localparam int unsigned ST_OSC   = 1;

  // vector table slot per trap class
  localparam int unsigned SLOT_OSC   = 1;
  localparam int unsigned SLOT_ADDR  = 2;
  localparam int unsigned SLOT_STACK = 3;
  localparam int unsigned SLOT_MATH  = 4;

  typedef struct packed {
    logic [3:0] math;   // [0]=div0 [1]=ovf [2]=covf [3]=shift
    logic       addr;
    logic       stack;
    logic       osc;
  } trap_evt_t;
endpackage

// File: rtl/trap_detect.sv
module trap_detect
  import trap_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned SH_W     = 5,
  parameter logic [AW-1:0] DATA_TOP = 16'h2000,
  parameter logic [AW-1:0] SP_FLOOR = 16'h0800
) (
  input  logic            div_zero_i,
  input  logic            carry31_a_i,
  input  logic            carry31_b_i,
  input  logic            carry39_a_i,
  input  logic            carry39_b_i,
  input  logic            sat31_a_i,
  input  logic            sat31_b_i,
  input  logic            ova_en_i,
  input  logic            ovb_en_i,
  input  logic            cov_en_i,
  input  logic            sh_valid_i,
  input  logic            sh_byte_i,
  input  logic [SH_W-1:0] sh_cnt_i,
  input  logic            mem_valid_i,
  input  logic            mem_word_i,
  input  logic [AW-1:0]   mem_addr_i,
  input  logic            prog_unimpl_i,
  input  logic            sp_chk_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [AW-1:0]   sp_lim_i,
  input  logic            osc_fail_i,
  output trap_evt_t       evt_o
);
  localparam logic [SH_W-1:0] WORD_MAX = SH_W'(16);
  localparam logic [SH_W-1:0] BYTE_MAX = SH_W'(8);

  logic ovf_a, ovf_b, sh_bad, misalign, data_oob;

  assign ovf_a    = carry31_a_i & ova_en_i & ~sat31_a_i;
  assign ovf_b    = carry31_b_i & ovb_en_i & ~sat31_b_i;
  assign sh_bad   = sh_valid_i & (sh_cnt_i > (sh_byte_i ? BYTE_MAX : WORD_MAX));
  assign misalign = mem_valid_i & mem_word_i & mem_addr_i[0];
  assign data_oob = mem_valid_i & (mem_addr_i >= DATA_TOP);

  always_comb begin
    evt_o.math[0] = div_zero_i;
    evt_o.math[1] = ovf_a | ovf_b;
    evt_o.math[2] = cov_en_i & (carry39_a_i | carry39_b_i);
    evt_o.math[3] = sh_bad;
    evt_o.addr    = misalign | data_oob | prog_unimpl_i;
    evt_o.stack   = sp_chk_i & ((sp_i < SP_FLOOR) | (sp_i > sp_lim_i));
    evt_o.osc     = osc_fail_i;
  end
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter logic [AW-1:0] SP_LIM_RST = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  trap_evt_t     evt_i,
  input  logic          reg_we_i,
  input  logic          reg_sel_i,
  input  logic [15:0]   reg_wdata_i,
  output logic [15:0]   reg_rdata_o,
  output logic          nest_dis_o,
  output logic          ova_en_o,
  output logic          ovb_en_o,
  output logic          cov_en_o,
  output logic [AW-1:0] sp_lim_o,
  output logic [3:0]    math_cause_o,
  output logic          st_addr_o,
  output logic          st_stack_o,
  output logic          st_osc_o
);
  logic [3:0]    cause_q;
  logic          addr_q, stack_q, osc_q;
  logic          nest_q, ova_q, ovb_q, cov_q;
  logic [AW-1:0] lim_q;
  logic          ctrl_wr, lim_wr;

  assign ctrl_wr = reg_we_i & ~reg_sel_i;
  assign lim_wr  = reg_we_i &  reg_sel_i;

  // status: write-0-to-clear, a new fault in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      addr_q  <= 1'b0;
      stack_q <= 1'b0;
      osc_q   <= 1'b0;
    end else begin
      cause_q <= ((ctrl_wr & ~reg_wdata_i[ST_MATH])  ? 4'b0 : cause_q) | evt_i.math;
      addr_q  <= ((ctrl_wr & ~reg_wdata_i[ST_ADDR])  ? 1'b0 : addr_q)  | evt_i.addr;
      stack_q <= ((ctrl_wr & ~reg_wdata_i[ST_STACK]) ? 1'b0 : stack_q) | evt_i.stack;
      osc_q   <= ((ctrl_wr & ~reg_wdata_i[ST_OSC])   ? 1'b0 : osc_q)   | evt_i.osc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nest_q <= 1'b0;
      ova_q  <= 1'b0;
      ovb_q  <= 1'b0;
      cov_q  <= 1'b0;
      lim_q  <= SP_LIM_RST;
    end else begin
      if (ctrl_wr) begin
        nest_q <= reg_wdata_i[CB_NEST];
        ova_q  <= reg_wdata_i[CB_OVA];
        ovb_q  <= reg_wdata_i[CB_OVB];
        cov_q  <= reg_wdata_i[CB_COV];
      end
      if (lim_wr) lim_q <= reg_wdata_i[AW-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i) begin
      reg_rdata_o[AW-1:0] = lim_q;
    end else begin
      reg_rdata_o[CB_NEST]  = nest_q;
      reg_rdata_o[CB_OVA]   = ova_q;
      reg_rdata_o[CB_OVB]   = ovb_q;
      reg_rdata_o[CB_COV]   = cov_q;
      reg_rdata_o[ST_MATH]  = |cause_q;
      reg_rdata_o[ST_ADDR]  = addr_q;
      reg_rdata_o[ST_STACK] = stack_q;
      reg_rdata_o[ST_OSC]   = osc_q;
    end
  end

  assign nest_dis_o   = nest_q;
  assign ova_en_o     = ova_q;
  assign ovb_en_o     = ovb_q;
  assign cov_en_o     = cov_q;
  assign sp_lim_o     = lim_q;
  assign math_cause_o = cause_q;
  assign st_addr_o    = addr_q;
  assign st_stack_o   = stack_q;
  assign st_osc_o     = osc_q;

  assert_div0_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.math[0] |=> cause_q[0]);

  assert_sticky_osc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_q && !(ctrl_wr && !reg_wdata_i[ST_OSC])) |=> osc_q);

  assert_sticky_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_q && !(ctrl_wr && !reg_wdata_i[ST_ADDR])) |=> addr_q);

  assert_no_sw_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stack_q && !evt_i.stack) |=> !stack_q);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned VEC_W    = 24,
  parameter logic [VEC_W-1:0] VEC_BASE = 24'h000004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       math_cause_i,
  input  logic             st_addr_i,
  input  logic             st_stack_i,
  input  logic             st_osc_i,
  input  logic [3:0]       cpu_ipl_i,
  input  logic             nest_dis_i,
  output logic             trap_req_o,
  output logic [3:0]       trap_level_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  localparam int unsigned NLVL = 16;
  localparam logic [3:0]  HW_MIN = LVL_STACK;

  logic [NLVL-1:0] pend;
  logic [3:0]      lvl;
  int unsigned     slot;
  logic            preempt_ok;

  assign pend = {1'b0, st_osc_i, st_addr_i, st_stack_i, math_cause_i, 8'b0};

  always_comb begin
    lvl = '0;
    for (int i = 8; i < NLVL; i++)
      if (pend[i]) lvl = 4'(i);
  end

  always_comb begin
    unique case (lvl)
      LVL_OSC:   slot = SLOT_OSC;
      LVL_ADDR:  slot = SLOT_ADDR;
      LVL_STACK: slot = SLOT_STACK;
      default:   slot = SLOT_MATH;
    endcase
  end

  // hardware-level service is never preempted; nest disable blocks any trap-on-trap
  assign preempt_ok   = (cpu_ipl_i < HW_MIN) & ~(nest_dis_i & cpu_ipl_i[3]);
  assign trap_req_o   = (lvl != '0) & (lvl > cpu_ipl_i) & preempt_ok;
  assign trap_level_o = lvl;
  assign trap_vec_o   = VEC_BASE + VEC_W'(2 * slot);

  assert_level_bit3_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> trap_level_o[3]);

  assert_req_above_cpu_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> (trap_level_o > cpu_ipl_i));
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned SH_W       = 5,
  parameter int unsigned VEC_W      = 24,
  parameter logic [AW-1:0] DATA_TOP   = 16'h2000,
  parameter logic [AW-1:0] SP_FLOOR   = 16'h0800,
  parameter logic [AW-1:0] SP_LIM_RST = 16'hFFFF,
  parameter logic [VEC_W-1:0] VEC_BASE = 24'h000004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_zero_i,
  input  logic             carry31_a_i,
  input  logic             carry31_b_i,
  input  logic             carry39_a_i,
  input  logic             carry39_b_i,
  input  logic             sat31_a_i,
  input  logic             sat31_b_i,
  input  logic             sh_valid_i,
  input  logic             sh_byte_i,
  input  logic [SH_W-1:0]  sh_cnt_i,
  input  logic             mem_valid_i,
  input  logic             mem_word_i,
  input  logic [AW-1:0]    mem_addr_i,
  input  logic             prog_unimpl_i,
  input  logic             sp_chk_i,
  input  logic [AW-1:0]    sp_i,
  input  logic             osc_fail_i,
  input  logic [3:0]       cpu_ipl_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [15:0]      reg_wdata_i,
  output logic [15:0]      reg_rdata_o,
  output logic             trap_req_o,
  output logic [3:0]       trap_level_o,
  output logic [VEC_W-1:0] trap_vec_o
);
  trap_evt_t     evt;
  logic          nest_dis, ova_en, ovb_en, cov_en;
  logic [AW-1:0] sp_lim;
  logic [3:0]    math_cause;
  logic          st_addr, st_stack, st_osc;

  trap_detect #(.AW(AW), .SH_W(SH_W), .DATA_TOP(DATA_TOP), .SP_FLOOR(SP_FLOOR)) u_detect (
    .div_zero_i, .carry31_a_i, .carry31_b_i, .carry39_a_i, .carry39_b_i,
    .sat31_a_i, .sat31_b_i,
    .ova_en_i(ova_en), .ovb_en_i(ovb_en), .cov_en_i(cov_en),
    .sh_valid_i, .sh_byte_i, .sh_cnt_i,
    .mem_valid_i, .mem_word_i, .mem_addr_i, .prog_unimpl_i,
    .sp_chk_i, .sp_i, .sp_lim_i(sp_lim), .osc_fail_i,
    .evt_o(evt)
  );

  trap_csr #(.AW(AW), .SP_LIM_RST(SP_LIM_RST)) u_csr (
    .clk_i, .rst_ni, .evt_i(evt),
    .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .nest_dis_o(nest_dis), .ova_en_o(ova_en), .ovb_en_o(ovb_en), .cov_en_o(cov_en),
    .sp_lim_o(sp_lim), .math_cause_o(math_cause),
    .st_addr_o(st_addr), .st_stack_o(st_stack), .st_osc_o(st_osc)
  );

  trap_arbiter #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_arb (
    .clk_i, .rst_ni,
    .math_cause_i(math_cause), .st_addr_i(st_addr), .st_stack_i(st_stack),
    .st_osc_i(st_osc), .cpu_ipl_i, .nest_dis_i(nest_dis),
    .trap_req_o, .trap_level_o, .trap_vec_o
  );

  assert_osc_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fail_i |=> (trap_level_o == LVL_OSC));
endmodule

// File: tb/tb_trap_unit.sv
`timescale 1ns/1ps
module tb_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_zero = 0, c31a = 0, c31b = 0, c39a = 0, c39b = 0, s31a = 0, s31b = 0;
  logic        sh_valid = 0, sh_byte = 0;
  logic [4:0]  sh_cnt = '0;
  logic        mem_valid = 0, mem_word = 0, prog_unimpl = 0;
  logic [15:0] mem_addr = '0;
  logic        sp_chk = 0;
  logic [15:0] sp = '0;
  logic        osc_fail = 0;
  logic [3:0]  cpu_ipl = '0;
  logic        we = 0, sel = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req;
  logic [3:0]  level;
  logic [23:0] vec;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .div_zero_i(div_zero), .carry31_a_i(c31a), .carry31_b_i(c31b),
    .carry39_a_i(c39a), .carry39_b_i(c39b), .sat31_a_i(s31a), .sat31_b_i(s31b),
    .sh_valid_i(sh_valid), .sh_byte_i(sh_byte), .sh_cnt_i(sh_cnt),
    .mem_valid_i(mem_valid), .mem_word_i(mem_word), .mem_addr_i(mem_addr),
    .prog_unimpl_i(prog_unimpl), .sp_chk_i(sp_chk), .sp_i(sp), .osc_fail_i(osc_fail),
    .cpu_ipl_i(cpu_ipl), .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trap_req_o(req), .trap_level_o(level), .trap_vec_o(vec)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [15:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0; sel = 0;
  endtask

  task automatic rd(logic s, output logic [15:0] d);
    sel = s; #1; d = rdata; sel = 0; #1;
  endtask

  task automatic idle_inputs;
    div_zero = 0; c31a = 0; c31b = 0; c39a = 0; c39b = 0;
    sh_valid = 0; mem_valid = 0; prog_unimpl = 0; sp_chk = 0; osc_fail = 0;
  endtask

  // fault strobes are set by caller before this; one edge captures them
  task automatic step;
    @(negedge clk); idle_inputs();
  endtask

  // returns at a negedge with status registered
  task automatic expect_lvl(string tag, logic [3:0] el);
    logic [23:0] ev;
    ev = (el == 14) ? 24'h6 : (el == 13) ? 24'h8 : (el == 12) ? 24'hA : 24'hC;
    check({tag, " req"}, {31'b0, req}, {31'b0, el != 0});
    check({tag, " level"}, {28'b0, level}, {28'b0, el});
    if (el != 0) check({tag, " vec"}, {8'b0, vec}, {8'b0, ev});
  endtask

  function automatic logic [3:0] max_lvl(bit d0, bit st, bit ad, bit os);
    return os ? 4'd14 : ad ? 4'd13 : st ? 4'd12 : d0 ? 4'd8 : 4'd0;
  endfunction

  initial begin
    logic [15:0] r;
    logic [15:0] en;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1
    rd(0, r); check("R1 ctrl reset", {16'b0, r}, 32'h0);
    rd(1, r); check("R1 limit reset", {16'b0, r}, 32'hFFFF);
    check("R1 no req", {31'b0, req}, 0);

    // R2
    @(negedge clk); div_zero = 1; step();
    rd(0, r); check("R2 status bit4", {31'b0, r[4]}, 1);
    expect_lvl("R2", 8);
    wr(0, 16'h0000);

    // R5 shift sweep
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 32; c++) begin
        @(negedge clk); sh_valid = 1; sh_byte = b[0]; sh_cnt = 5'(c); step();
        expect_lvl("R5 shift", (c > (b ? 8 : 16)) ? 4'd11 : 4'd0);
        wr(0, 16'h0000);
      end

    // R3 overflow sweep
    for (int m = 0; m < 64; m++) begin
      bit ea, eb, sa, sb, ca, cb, hit;
      {ea, eb, sa, sb, ca, cb} = 6'(m);
      en = (ea ? 16'h0400 : 16'h0) | (eb ? 16'h0200 : 16'h0);
      wr(0, en);
      @(negedge clk); s31a = sa; s31b = sb; c31a = ca; c31b = cb; step();
      hit = (ca & ea & ~sa) | (cb & eb & ~sb);
      expect_lvl("R3 ovf", hit ? 4'd9 : 4'd0);
      s31a = 0; s31b = 0;
      wr(0, 16'h0000);
    end

    // R4 catastrophic overflow
    for (int m = 0; m < 8; m++) begin
      bit e, ca, cb;
      {e, ca, cb} = 3'(m);
      wr(0, e ? 16'h0100 : 16'h0);
      @(negedge clk); c39a = ca; c39b = cb; step();
      expect_lvl("R4 covf", (e & (ca | cb)) ? 4'd10 : 4'd0);
      wr(0, 16'h0000);
    end

    // R6 address faults
    begin
      logic [15:0] adr [6] = '{16'h0101, 16'h0101, 16'h0100, 16'h2000, 16'h1FFE, 16'h2001};
      bit          wd  [6] = '{1, 0, 1, 0, 1, 1};
      bit          ex  [6] = '{1, 0, 0, 1, 0, 1};
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); mem_valid = 1; mem_word = wd[i]; mem_addr = adr[i]; step();
        rd(0, r); check("R6 status bit3", {31'b0, r[3]}, {31'b0, ex[i]});
        expect_lvl("R6 addr", ex[i] ? 4'd13 : 4'd0);
        wr(0, 16'h0000);
      end
      @(negedge clk); prog_unimpl = 1; step();
      expect_lvl("R6 prog", 13);
      wr(0, 16'h0000);
    end

    // R7 stack
    wr(1, 16'h1000);
    rd(1, r); check("R7 limit readback", {16'b0, r}, 32'h1000);
    begin
      logic [15:0] spv [6] = '{16'h07FE, 16'h0800, 16'h0C00, 16'h1000, 16'h1002, 16'h0000};
      bit          ex  [6] = '{1, 0, 0, 0, 1, 1};
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); sp_chk = 1; sp = spv[i]; step();
        rd(0, r); check("R7 status bit2", {31'b0, r[2]}, {31'b0, ex[i]});
        expect_lvl("R7 stack", ex[i] ? 4'd12 : 4'd0);
        wr(0, 16'h0000);
      end
    end

    // R8
    @(negedge clk); osc_fail = 1; step();
    rd(0, r); check("R8 status bit1", {31'b0, r[1]}, 1);
    expect_lvl("R8 osc", 14);
    wr(0, 16'h0000);

    // R9 collisions over all subsets
    for (int m = 0; m < 16; m++) begin
      @(negedge clk);
      div_zero = m[0]; sp_chk = m[1]; sp = m[1] ? 16'h0000 : 16'h0900;
      mem_valid = m[2]; mem_word = 1; mem_addr = 16'h0003; osc_fail = m[3];
      step();
      expect_lvl("R9 mix", max_lvl(m[0], m[1], m[2], m[3]));
      wr(0, 16'h0000);
    end
    @(negedge clk); div_zero = 1; sh_valid = 1; sh_byte = 1; sh_cnt = 5'd9; step();
    expect_lvl("R9 math sublevel", 11);
    wr(0, 16'h0000);

    // R10 sticky
    @(negedge clk); osc_fail = 1; step();
    repeat (5) @(negedge clk);
    rd(0, r); check("R10 held", {31'b0, r[1]}, 1);
    wr(0, 16'h001E);
    rd(0, r); check("R10 write1 keeps", {16'b0, r}, 32'h0002);
    @(negedge clk); we = 1; sel = 0; wdata = 16'h0000; osc_fail = 1;
    @(negedge clk); we = 0; idle_inputs();
    rd(0, r); check("R10 fault beats clear", {31'b0, r[1]}, 1);
    wr(0, 16'h0000);
    rd(0, r); check("R10 cleared", {16'b0, r}, 32'h0);
    wr(0, 16'h001E);
    rd(0, r); check("R10 write1 no set", {16'b0, r}, 32'h0);
    check("R10 no req", {31'b0, req}, 0);

    // R11 nesting
    for (int nd = 0; nd < 2; nd++)
      for (int k = 0; k < 2; k++) begin
        logic [3:0] pl;
        en = nd ? 16'h8000 : 16'h0;
        wr(0, en);
        @(negedge clk); if (k == 0) div_zero = 1; else osc_fail = 1; step();
        pl = k ? 4'd14 : 4'd8;
        for (int ipl = 0; ipl < 16; ipl++) begin
          bit er;
          cpu_ipl = 4'(ipl); #1;
          er = (pl > ipl) && (ipl < 12) && !(nd && ipl >= 8);
          check("R11 nest", {31'b0, req}, {31'b0, er});
        end
        cpu_ipl = 0;
        wr(0, en);
      end

    // R12
    wr(0, 16'hFFFF);
    rd(0, r); check("R12 ctrl readback", {16'b0, r}, 32'h8700);
    wr(0, 16'h0000);
    rd(0, r); check("R12 ctrl cleared", {16'b0, r}, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule